// File: doc/BRIEF.md
# Serial Receive Line Status Tracker

This block sits between the receive deserializer of a serial port and the host register bus. Each completed character arrives with three error tags: parity, framing and break. The block holds the characters in a 16-entry queue in queued mode, or in a single holding slot in direct mode. It reports the receive condition through an 8-bit line status register. It also raises a receiver line status interrupt when an error bit is set and the interrupt is enabled.

The error tags travel with their character. They are shown only when that character is at the head of storage. Once shown, a tag is held until the host reads the status register, even if the character has since been popped. A character that arrives while storage is full is dropped, and the drop is recorded as an overrun. Changing between queued and direct mode empties the storage.

Top module: `uart_rx_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 from the cycle after a character is accepted into empty storage. It returns to 0 in the cycle after the last stored character is read at address 0.
- R2: A host read at address 0 returns the head character, or 0 when storage is empty. A read at address 5 returns the status byte. Any other address returns 0. The status byte bits are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 `tx_hold_empty_i`, 6 `tx_idle_i`, 7 queued error pending.
- R3: In direct mode (`fifo_mode_i` = 0) storage is one character. Bits 2 to 4 show the tags of the held character from the cycle after it is accepted.
- R4: In queued mode (`fifo_mode_i` = 1) up to 16 characters are held in arrival order. Bits 2 to 4 show only the tags of the head character. A bad character behind clean ones is not shown until the earlier ones are read.
- R5: Once bits 1 to 4 are shown, they stay set until a status read, even after the character that caused them is read. A status read returns the value before the clear. The bits then clear, unless the new head still carries the tag.
- R6: A character that arrives while storage is full sets bit 1 in the next cycle and is discarded, and the stored data is unchanged. Storage is full at 1 character in direct mode and at 16 in queued mode. A data read in the same cycle frees a slot, so the character is accepted and no overrun occurs.
- R7: Bit 7 is 1 in queued mode while any stored character carries a tag. It is always 0 in direct mode.
- R8: `lsi_irq_o` is 1 exactly when `lsi_en_i` is 1 and any of bits 1 to 4 is 1.
- R9: When a status read and a new overrun fall in the same cycle, the overrun wins and bit 1 is still 1 afterwards.
- R10: A change of `fifo_mode_i` empties storage (bit 0 becomes 0) and discards any character arriving in that cycle. Bits that are already held stay set.
- R11: After reset, bits 0 to 4 and bit 7 are 0, and `lsi_irq_o` is 0. Reset asserts asynchronously and is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_i | input | 1 | 1 = queued mode, 0 = direct mode |
| rx_valid_i | input | 1 | One-cycle strobe: a character has completed |
| rx_data_i | input | 8 | Completed character |
| rx_pe_i | input | 1 | Parity error tag of the character |
| rx_fe_i | input | 1 | Framing error tag of the character |
| rx_bi_i | input | 1 | Break tag of the character |
| host_rd_i | input | 1 | One-cycle host read strobe |
| host_addr_i | input | 3 | Host register offset |
| host_rdata_o | output | 8 | Host read data for the current address |
| tx_hold_empty_i | input | 1 | Transmit holding empty, shown as status bit 5 |
| tx_idle_i | input | 1 | Transmitter idle, shown as status bit 6 |
| lsi_en_i | input | 1 | Line status interrupt enable |
| lsr_o | output | 8 | Live line status byte |
| lsi_irq_o | output | 1 | Receiver line status interrupt |

## Verification
Two events can fall in the same cycle: a status read that clears the held bits, and a new error event that sets them. One example is a character arriving into full storage while the host reads address 5. Another is a data read that pops a flagged head while a clean character arrives behind it. Directed sequences force each collision on purpose, and seeded random traffic with frequent reads and arrivals produces many more. Each cycle, the status byte, read data and interrupt are compared with a queue-and-flag model in the bench built from the requirements. Under that model, the bit that a read cleared must reappear when a new event lands in the same cycle.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic bi;
    logic fe;
    logic pe;
  } rx_tags_t;

  typedef struct packed {
    rx_tags_t          tags;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam logic [2:0] ADDR_RXDATA = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd5;

  // held error bits, index order inside the sticky vector
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  localparam int NUM_ERR = 4;

endpackage

// File: rtl/uart_rxs_rst_sync.sv
module uart_rxs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_n;

  assign sync_n = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_n;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/uart_rxs_store.sv
module uart_rxs_store
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush_i,
  input  logic      cap_one_i,
  input  logic      push_i,
  input  logic      pop_i,
  input  rx_entry_t wr_entry_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic      err_any_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  rx_entry_t mem [DEPTH];

  logic [AW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n, err_q, err_n;
  logic          push_err, pop_err;

  assign head_o    = mem[rp_q];
  assign empty_o   = (cnt_q == '0);
  assign full_o    = cap_one_i ? !empty_o : (cnt_q == FULL_CNT);
  assign err_any_o = (err_q != '0);

  assign push_err = push_i && (wr_entry_i.tags != '0);
  assign pop_err  = pop_i  && (head_o.tags != '0);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    err_n = err_q;
    if (flush_i) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
      err_n = '0;
    end else begin
      if (push_i) wp_n = (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_n = (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
      cnt_n = cnt_q + CW'(push_i) - CW'(pop_i);
      err_n = err_q + CW'(push_err) - CW'(pop_err);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      err_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      err_q <= err_n;
    end
  end

  // storage array: written under its own enable, not reset
  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= wr_entry_i;
  end

endmodule

// File: rtl/uart_rxs_sticky.sv
module uart_rxs_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic hold_q, hold_n;

  // a read clears what was shown; an event in the same cycle survives it
  always_comb begin
    if (clr_i) hold_n = set_i;
    else       hold_n = hold_q | live_i | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  assign flag_o = hold_q | live_i;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pe_i,
  input  logic              rx_fe_i,
  input  logic              rx_bi_i,
  input  logic              host_rd_i,
  input  logic [2:0]        host_addr_i,
  output logic [7:0]        host_rdata_o,
  input  logic              tx_hold_empty_i,
  input  logic              tx_idle_i,
  input  logic              lsi_en_i,
  output logic [7:0]        lsr_o,
  output logic              lsi_irq_o
);

  logic rst_sync_n;

  uart_rxs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // mode register: any change flushes storage
  logic mode_q, mode_n, mode_flip;

  assign mode_n    = fifo_mode_i;
  assign mode_flip = mode_q ^ fifo_mode_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) mode_q <= 1'b0;
    else             mode_q <= mode_n;
  end

  logic data_rd, status_rd;
  assign data_rd   = host_rd_i && (host_addr_i == ADDR_RXDATA);
  assign status_rd = host_rd_i && (host_addr_i == ADDR_STATUS);

  rx_entry_t head, wr_entry;
  logic      store_empty, store_full, store_err_any;
  logic      pop, push, overrun;

  assign pop     = data_rd && !store_empty && !mode_flip;
  assign push    = rx_valid_i && !mode_flip && (!store_full || pop);
  assign overrun = rx_valid_i && !mode_flip && store_full && !pop;

  always_comb begin
    wr_entry.data    = rx_data_i;
    wr_entry.tags.pe = rx_pe_i;
    wr_entry.tags.fe = rx_fe_i;
    wr_entry.tags.bi = rx_bi_i;
  end

  uart_rxs_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .flush_i    (mode_flip),
    .cap_one_i  (!mode_q),
    .push_i     (push),
    .pop_i      (pop),
    .wr_entry_i (wr_entry),
    .head_o     (head),
    .empty_o    (store_empty),
    .full_o     (store_full),
    .err_any_o  (store_err_any)
  );

  // tags are live only while their character is at the head
  logic [NUM_ERR-1:0] err_live, err_set, err_flag;

  always_comb begin
    err_live          = '0;
    err_set           = '0;
    err_live[ERR_PAR] = !store_empty && head.tags.pe;
    err_live[ERR_FRM] = !store_empty && head.tags.fe;
    err_live[ERR_BRK] = !store_empty && head.tags.bi;
    err_set[ERR_OVR]  = overrun;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_ERR; g++) begin : g_err
      uart_rxs_sticky u_hold (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .live_i (err_live[g]),
        .set_i  (err_set[g]),
        .clr_i  (status_rd),
        .flag_o (err_flag[g])
      );
    end
  endgenerate

  always_comb begin
    lsr_o    = '0;
    lsr_o[0] = !store_empty;
    lsr_o[1] = err_flag[ERR_OVR];
    lsr_o[2] = err_flag[ERR_PAR];
    lsr_o[3] = err_flag[ERR_FRM];
    lsr_o[4] = err_flag[ERR_BRK];
    lsr_o[5] = tx_hold_empty_i;
    lsr_o[6] = tx_idle_i;
    lsr_o[7] = mode_q && store_err_any;
  end

  assign lsi_irq_o = lsi_en_i && (err_flag != '0);

  always_comb begin
    case (host_addr_i)
      ADDR_RXDATA: host_rdata_o = store_empty ? '0 : head.data;
      ADDR_STATUS: host_rdata_o = lsr_o;
      default:     host_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/uart_rxs_checker.sv
module uart_rxs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid_i,
  input logic       host_rd_i,
  input logic [2:0] host_addr_i,
  input logic       lsi_en_i,
  input logic [7:0] lsr_o,
  input logic       lsi_irq_o,
  input logic       store_full,
  input logic       pop,
  input logic       mode_flip
);

  logic status_rd;
  assign status_rd = host_rd_i && (host_addr_i == 3'd5);

  // R1: an arrival into empty storage raises data ready
  a_r1_dr_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !lsr_o[0] && !mode_flip) |=> lsr_o[0]);

  // R5: shown parity and break bits hold until a status read
  a_r5_par_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_o[2] && !status_rd) |=> lsr_o[2]);

  a_r5_brk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_o[4] && !status_rd) |=> lsr_o[4]);

  // R6: arrival into full storage without a pop flags overrun
  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && store_full && !pop && !mode_flip) |=> lsr_o[1]);

  // R9: status read colliding with a new overrun leaves it set
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && rx_valid_i && store_full && !pop && !mode_flip) |=> lsr_o[1]);

  // R7: an empty store has no pending queued error
  a_r7_empty_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !lsr_o[0] |-> !lsr_o[7]);

  // R8: no interrupt without enable
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !lsi_en_i |-> !lsi_irq_o);

endmodule

bind uart_rx_status uart_rxs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .rx_valid_i  (rx_valid_i),
  .host_rd_i   (host_rd_i),
  .host_addr_i (host_addr_i),
  .lsi_en_i    (lsi_en_i),
  .lsr_o       (lsr_o),
  .lsi_irq_o   (lsi_irq_o),
  .store_full  (store_full),
  .pop         (pop),
  .mode_flip   (mode_flip)
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_mode_i, rx_valid_i, rx_pe_i, rx_fe_i, rx_bi_i;
  logic [7:0] rx_data_i;
  logic       host_rd_i;
  logic [2:0] host_addr_i;
  logic [7:0] host_rdata_o, lsr_o;
  logic       tx_hold_empty_i, tx_idle_i, lsi_en_i, lsi_irq_o;

  always #2.5 clk = ~clk;

  uart_rx_status u_uart_rx_status (.*);

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model: queue of {bi,fe,pe,data}, held bits {brk,frm,par,ovr}
  logic [10:0] mq[$];
  logic [3:0]  m_hold;
  logic        m_mode;

  task automatic expect8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] m_head_tags();
    return (mq.size() != 0) ? mq[0][10:8] : 3'b000;
  endfunction

  function automatic logic [7:0] m_lsr();
    logic [2:0] ht;
    logic       any;
    logic [7:0] r;
    ht  = m_head_tags();
    any = 1'b0;
    foreach (mq[i]) any |= (mq[i][10:8] != 3'b000);
    r    = 8'h00;
    r[0] = (mq.size() != 0);
    r[1] = m_hold[0];
    r[2] = m_hold[1] | ht[0];
    r[3] = m_hold[2] | ht[1];
    r[4] = m_hold[3] | ht[2];
    r[5] = tx_hold_empty_i;
    r[6] = tx_idle_i;
    r[7] = m_mode & any;
    return r;
  endfunction

  function automatic logic [7:0] m_rdata();
    if (host_addr_i == 3'd0) return (mq.size() != 0) ? mq[0][7:0] : 8'h00;
    if (host_addr_i == 3'd5) return m_lsr();
    return 8'h00;
  endfunction

  task automatic compare_all();
    logic [7:0] e;
    e = m_lsr();
    expect8("R1 data ready", {7'd0, lsr_o[0]}, {7'd0, e[0]});
    expect8("R6 overrun", {7'd0, lsr_o[1]}, {7'd0, e[1]});
    expect8(m_mode ? "R4 head tags" : "R3 held tags", {5'd0, lsr_o[4:2]}, {5'd0, e[4:2]});
    expect8("R2 tx bits", {6'd0, lsr_o[6:5]}, {6'd0, e[6:5]});
    expect8("R7 queued error", {7'd0, lsr_o[7]}, {7'd0, e[7]});
    expect8("R8 irq", {7'd0, lsi_irq_o}, {7'd0, lsi_en_i & (e[4:1] != 4'd0)});
    expect8("R2 read data", host_rdata_o, m_rdata());
  endtask

  task automatic model_step();
    logic       st_rd, pop, full, accept, ovr;
    logic [3:0] live;
    live  = {m_head_tags(), 1'b0};
    st_rd = host_rd_i && (host_addr_i == 3'd5);
    ovr   = 1'b0;
    if (fifo_mode_i != m_mode) begin
      mq.delete();
      m_mode = fifo_mode_i;
    end else begin
      full   = (mq.size() == (m_mode ? 16 : 1));
      pop    = host_rd_i && (host_addr_i == 3'd0) && (mq.size() != 0);
      accept = rx_valid_i && (!full || pop);
      ovr    = rx_valid_i && full && !pop;
      if (pop) void'(mq.pop_front());
      if (accept) mq.push_back({rx_bi_i, rx_fe_i, rx_pe_i, rx_data_i});
    end
    m_hold = st_rd ? {3'b000, ovr} : (m_hold | live | {3'b000, ovr});
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic [2:0] t,
                     input logic rd, input logic [2:0] a, input logic mode);
    @(negedge clk);
    rx_valid_i  = v;
    rx_data_i   = d;
    {rx_bi_i, rx_fe_i, rx_pe_i} = t;
    host_rd_i   = rd;
    host_addr_i = a;
    fifo_mode_i = mode;
    #1;
    compare_all();
    model_step();
  endtask

  task automatic idle_chk(input logic mode, input logic [7:0] exp, input string tag);
    cyc(1'b0, 8'h00, 3'b000, 1'b0, 3'd1, mode);
    expect8(tag, lsr_o, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    fifo_mode_i = 1'b0; rx_valid_i = 1'b0; rx_data_i = 8'h00;
    rx_pe_i = 1'b0; rx_fe_i = 1'b0; rx_bi_i = 1'b0;
    host_rd_i = 1'b0; host_addr_i = 3'd1;
    tx_hold_empty_i = 1'b1; tx_idle_i = 1'b1; lsi_en_i = 1'b1;
    m_hold = 4'h0; m_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R11 reset state
    @(negedge clk); #1;
    expect8("R11 reset status", lsr_o, 8'h60);
    expect8("R11 reset irq", {7'd0, lsi_irq_o}, 8'h00);

    // direct mode: R1, R2, R3
    cyc(1'b1, 8'h41, 3'b000, 1'b0, 3'd1, 1'b0);
    idle_chk(1'b0, 8'h61, "R1 ready after arrival");
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b0);
    expect8("R2 data read", host_rdata_o, 8'h41);
    idle_chk(1'b0, 8'h60, "R1 ready cleared");
    cyc(1'b1, 8'h55, 3'b001, 1'b0, 3'd1, 1'b0);
    idle_chk(1'b0, 8'h65, "R3 parity shown");
    expect8("R8 irq on parity", {7'd0, lsi_irq_o}, 8'h01);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b0);
    idle_chk(1'b0, 8'h64, "R5 parity held after pop");
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd5, 1'b0);
    expect8("R5 status read value", host_rdata_o, 8'h64);
    idle_chk(1'b0, 8'h60, "R5 cleared by status read");

    // R6 overrun in direct mode
    cyc(1'b1, 8'h11, 3'b000, 1'b0, 3'd1, 1'b0);
    cyc(1'b1, 8'h22, 3'b000, 1'b0, 3'd1, 1'b0);
    idle_chk(1'b0, 8'h63, "R6 overrun flagged");
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b0);
    expect8("R6 stored data kept", host_rdata_o, 8'h11);
    // R6 pop frees the slot in the same cycle
    cyc(1'b1, 8'h33, 3'b000, 1'b0, 3'd1, 1'b0);
    cyc(1'b1, 8'h44, 3'b000, 1'b1, 3'd0, 1'b0);
    expect8("R6 pop returns old", host_rdata_o, 8'h33);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b0);
    expect8("R6 same-cycle arrival kept", host_rdata_o, 8'h44);

    // R9 status read with a colliding overrun
    cyc(1'b1, 8'h66, 3'b000, 1'b0, 3'd1, 1'b0);
    cyc(1'b1, 8'h77, 3'b000, 1'b1, 3'd5, 1'b0);
    expect8("R9 read returns pre-clear", host_rdata_o, 8'h63);
    idle_chk(1'b0, 8'h63, "R9 overrun survives read");

    // R10 mode change flushes storage, held overrun stays
    cyc(1'b1, 8'h88, 3'b000, 1'b0, 3'd1, 1'b1);
    idle_chk(1'b1, 8'h62, "R10 flushed on mode change");
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd5, 1'b1);
    idle_chk(1'b1, 8'h60, "R10 status clean");

    // R4, R7, R8 queued mode: bad character behind two clean ones
    lsi_en_i = 1'b1;
    cyc(1'b1, 8'h10, 3'b000, 1'b0, 3'd1, 1'b1);
    cyc(1'b1, 8'h20, 3'b000, 1'b0, 3'd1, 1'b1);
    cyc(1'b1, 8'h30, 3'b010, 1'b0, 3'd1, 1'b1);
    idle_chk(1'b1, 8'hE1, "R4 framing deferred, R7 pending");
    expect8("R8 no irq while deferred", {7'd0, lsi_irq_o}, 8'h00);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b1);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b1);
    idle_chk(1'b1, 8'hE9, "R4 framing at head");
    expect8("R8 irq at head", {7'd0, lsi_irq_o}, 8'h01);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b1);
    idle_chk(1'b1, 8'h68, "R5 framing held, R7 cleared");
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd5, 1'b1);

    // R6 queued full at 16, R4 order
    for (int i = 0; i < 16; i++) cyc(1'b1, 8'(i), 3'b000, 1'b0, 3'd1, 1'b1);
    cyc(1'b1, 8'hFF, 3'b000, 1'b0, 3'd1, 1'b1);
    idle_chk(1'b1, 8'h63, "R6 queued overrun");
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd0, 1'b1);
      expect8("R4 arrival order", host_rdata_o, 8'(i));
    end
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd5, 1'b1);
    expect8("R2 unused address", 8'h00, 8'h00);
    cyc(1'b0, 8'h00, 3'b000, 1'b1, 3'd3, 1'b1);
    expect8("R2 other address reads zero", host_rdata_o, 8'h00);

    // constrained random traffic
    void'($urandom(32'd2024));
    begin
      logic mode;
      mode = 1'b1;
      for (int n = 0; n < 4000; n++) begin
        logic       v, rd;
        logic [2:0] t, a;
        int         r;
        if ($urandom_range(0, 399) == 0) mode = ~mode;
        v  = ($urandom_range(0, 9) < 4);
        t  = {($urandom_range(0, 19) == 0), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)};
        rd = ($urandom_range(0, 9) < 4);
        r  = $urandom_range(0, 9);
        a  = (r < 6) ? 3'd0 : (r < 9) ? 3'd5 : 3'd2;
        tx_hold_empty_i = 1'($urandom_range(0, 1));
        tx_idle_i       = 1'($urandom_range(0, 1));
        lsi_en_i        = ($urandom_range(0, 3) != 0);
        cyc(v, 8'($urandom_range(0, 255)), t, rd, a, mode);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL watchdog expired actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule